// File: doc/BRIEF.md
# Address-Filter Load Sequencer

This block carries out the command that fills an address filter from a table held in system memory. Software first programs three registers: a 16-bit upper address, a descriptor pointer that holds address bits 15:1, and a 5-bit descriptor count. Software then raises the start input. The block issues word reads through a request/acknowledge master port and builds each 32-bit read address from the upper address and the pointer. The pointer steps forward by one 16-bit word for every word accepted.

Each descriptor is four words long. The first word selects the filter slot. The next three words carry the 48-bit address, lowest word first. Once the fourth word is in, the block writes the slot into the filter and decrements the count. When the count reaches zero, the block fetches one more word and hands it to the filter as its slot-enable mask. It then raises a one-cycle done pulse and drops busy. After completion the pointer is left on the word just past the table and the count reads zero.

Top module: `cam_load_seq`

## Requirements
- R1: After reset, busy, done, mem_req, flt_wr and mask_wr are 0, and upper_addr, desc_ptr and desc_cnt read 0.
- R2: A configuration write with cfg_sel 0 loads upper_addr, with cfg_sel 1 loads desc_ptr with bit 0 forced to 0, and with cfg_sel 2 loads desc_cnt from cfg_wdata[4:0]. Every read address equals {upper_addr, desc_ptr}, so bit 0 is always 0.
- R3: desc_ptr increases by 2 (modulo 2^16) on each accepted read. After a load of N descriptors it equals its start value plus 2*(4N+1).
- R4: desc_cnt decrements by one as each descriptor's fourth word is accepted, and it reads 0 when the load completes.
- R5: The words of a descriptor are taken in this order: slot select (bits 3:0 used), address bits 15:0, bits 31:16, bits 47:32. In the cycle after the fourth word is accepted, flt_wr is 1 for one cycle with flt_idx and flt_word valid.
- R6: After the last descriptor, one more word is read. In the cycle after it is accepted, mask_wr and done are 1 for one cycle, mask_data holds that word, and busy is 0.
- R7: mem_req stays high, with mem_addr unchanged, until mem_ack is seen. A read is accepted on a clock edge where both mem_req and mem_ack are 1.
- R8: While busy, a start pulse and configuration writes have no effect.
- R9: If the load is started with desc_cnt equal to 0, only the mask word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 upper, 1 pointer, 2 count |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Begin a load (taken when idle) |
| upper_addr | output | 16 | Upper address register |
| desc_ptr | output | 16 | Descriptor pointer, bit 0 always 0 |
| desc_cnt | output | 5 | Remaining descriptor count |
| busy | output | 1 | Load in progress (command bit) |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| flt_wr | output | 1 | Filter slot write strobe |
| flt_idx | output | 4 | Filter slot number |
| flt_word | output | 48 | Filter slot address value |
| mask_wr | output | 1 | Filter enable-mask write strobe |
| mask_data | output | 16 | Filter enable-mask value |

## Verification
A read is accepted on the clock edge that sees mem_ack. The pointer and count change at that same edge. flt_wr, mask_wr and done appear in the one cycle that follows, and busy drops with done. The bench drives acknowledges on the falling edge. On every falling edge it first checks the results owed to an acknowledge accepted at the edge just passed, then checks the live request and address. No result is looked for earlier or later than that one-cycle slot. Acknowledge delays of zero to three cycles are drawn at random, so the order of checks holds for back-to-back and stalled reads alike.

// File: rtl/cam_load_pkg.sv
// Shared types for the address-filter load sequencer.
package cam_load_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } cl_state_t;

    typedef enum logic [1:0] {
        SEL_UPPER = 2'd0,
        SEL_PTR   = 2'd1,
        SEL_CNT   = 2'd2,
        SEL_NONE  = 2'd3
    } cl_sel_t;
endpackage

// File: rtl/cl_regs.sv
// Address and count registers of the load sequencer.
// Holds the upper address, the descriptor pointer (bit 0 forced to zero)
// and the descriptor count. Software writes are refused while locked.
// Assumes step pulses arrive only while locked.
module cl_regs #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              lock,
    input  logic              ptr_step,
    input  logic              cnt_step,
    output logic [WORD_W-1:0] upper,
    output logic [WORD_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt
);
    import cam_load_pkg::*;

    localparam logic [WORD_W-1:0] PTR_INC = WORD_W'(2);

    logic wr_ok;
    assign wr_ok = cfg_wr_en && !lock;

    // Upper address register: software-loaded only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upper <= '0;
        else if (wr_ok && cfg_sel == SEL_UPPER)
            upper <= cfg_wdata;
    end

    // Descriptor pointer: software load, or one word step per accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (wr_ok && cfg_sel == SEL_PTR)
            ptr <= {cfg_wdata[WORD_W-1:1], 1'b0};
        else if (ptr_step)
            ptr <= ptr + PTR_INC;
    end

    // Descriptor count: software load, or decrement per completed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_ok && cfg_sel == SEL_CNT)
            cnt <= cfg_wdata[CNT_W-1:0];
        else if (cnt_step)
            cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/cl_ctrl.sv
// Fetch controller of the load sequencer.
// Walks the descriptor fields, gathers the address words and raises the
// filter-write, mask-write and done pulses. Assumes mem_rdata is valid
// in any cycle where mem_req and mem_ack are both high.
module cl_ctrl #(
    parameter int WORD_W     = 16,
    parameter int IDX_W      = 4,
    parameter int ADDR_WORDS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         cnt_zero,
    input  logic                         mem_ack,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic                         mem_req,
    output logic                         busy,
    output logic                         done,
    output logic                         ptr_step,
    output logic                         cnt_step,
    output logic                         flt_wr,
    output logic [IDX_W-1:0]             flt_idx,
    output logic [ADDR_WORDS*WORD_W-1:0] flt_word,
    output logic                         mask_wr,
    output logic [WORD_W-1:0]            mask_data
);
    import cam_load_pkg::*;

    localparam int FIELDS = ADDR_WORDS + 1;
    localparam int FLD_W  = $clog2(FIELDS);
    localparam logic [FLD_W-1:0] FLD_LAST = FLD_W'(FIELDS - 1);

    cl_state_t         state;
    logic [FLD_W-1:0]  fld;
    logic [WORD_W-1:0] words [ADDR_WORDS];
    logic              take;

    assign mem_req  = (state == ST_FETCH);
    assign busy     = mem_req;
    assign take     = mem_req && mem_ack;
    assign ptr_step = take;
    assign cnt_step = take && !cnt_zero && (fld == FLD_LAST);

    // Pack the gathered address words, lowest word at the bottom.
    for (genvar g = 0; g < ADDR_WORDS; g++) begin : g_pack
        assign flt_word[g*WORD_W +: WORD_W] = words[g];
    end

    // Sequencing state, field counter and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            fld     <= '0;
            flt_wr  <= 1'b0;
            mask_wr <= 1'b0;
            done    <= 1'b0;
        end else begin
            flt_wr  <= 1'b0;
            mask_wr <= 1'b0;
            done    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_FETCH;
                        fld   <= '0;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (cnt_zero) begin
                            mask_wr <= 1'b1;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (fld == FLD_LAST) begin
                            flt_wr <= 1'b1;
                            fld    <= '0;
                        end else begin
                            fld <= fld + FLD_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Data capture: slot select, address words and the trailing mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_idx   <= '0;
            mask_data <= '0;
            for (int i = 0; i < ADDR_WORDS; i++) words[i] <= '0;
        end else if (take) begin
            if (cnt_zero)
                mask_data <= mem_rdata;
            else if (fld == '0)
                flt_idx <= mem_rdata[IDX_W-1:0];
            else
                words[fld - FLD_W'(1)] <= mem_rdata;
        end
    end
endmodule

// File: rtl/cam_load_seq.sv
// Top of the address-filter load sequencer.
// Joins the register file and the fetch controller and forms the 32-bit
// read address from the upper address and the pointer. Assumes the
// memory side holds mem_rdata valid with mem_ack.
module cam_load_seq #(
    parameter int WORD_W     = 16,
    parameter int CNT_W      = 5,
    parameter int IDX_W      = 4,
    parameter int ADDR_WORDS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr_en,
    input  logic [1:0]                   cfg_sel,
    input  logic [WORD_W-1:0]            cfg_wdata,
    input  logic                         start,
    output logic [WORD_W-1:0]            upper_addr,
    output logic [WORD_W-1:0]            desc_ptr,
    output logic [CNT_W-1:0]             desc_cnt,
    output logic                         busy,
    output logic                         done,
    output logic                         mem_req,
    output logic [2*WORD_W-1:0]          mem_addr,
    input  logic                         mem_ack,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic                         flt_wr,
    output logic [IDX_W-1:0]             flt_idx,
    output logic [ADDR_WORDS*WORD_W-1:0] flt_word,
    output logic                         mask_wr,
    output logic [WORD_W-1:0]            mask_data
);
    logic ptr_step;
    logic cnt_step;
    logic cnt_zero;

    assign cnt_zero = (desc_cnt == '0);
    assign mem_addr = {upper_addr, desc_ptr};

    cl_regs #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .lock      (busy),
        .ptr_step  (ptr_step),
        .cnt_step  (cnt_step),
        .upper     (upper_addr),
        .ptr       (desc_ptr),
        .cnt       (desc_cnt)
    );

    cl_ctrl #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ADDR_WORDS(ADDR_WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cnt_zero  (cnt_zero),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .busy      (busy),
        .done      (done),
        .ptr_step  (ptr_step),
        .cnt_step  (cnt_step),
        .flt_wr    (flt_wr),
        .flt_idx   (flt_idx),
        .flt_word  (flt_word),
        .mask_wr   (mask_wr),
        .mask_data (mask_data)
    );
endmodule

// File: rtl/cam_load_seq_chk.sv
// Protocol checker for the load sequencer, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module cam_load_seq_chk #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mem_req,
    input logic                 mem_ack,
    input logic [2*WORD_W-1:0]  mem_addr,
    input logic                 busy,
    input logic                 done,
    input logic                 flt_wr,
    input logic                 mask_wr,
    input logic [WORD_W-1:0]    desc_ptr,
    input logic [CNT_W-1:0]     desc_cnt
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    a_r2_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (desc_ptr == $past(desc_ptr) + WORD_W'(2)));

    a_r4_cnt_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (desc_cnt <= $past(desc_cnt)));

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && mask_wr));

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_wr && mask_wr));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind cam_load_seq cam_load_seq_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done),
    .flt_wr   (flt_wr),
    .mask_wr  (mask_wr),
    .desc_ptr (desc_ptr),
    .desc_cnt (desc_cnt)
);

// File: tb/cam_load_seq_bench.sv
// Self-checking bench: random and directed loads against a computed memory.
module cam_load_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [15:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [15:0] upper_addr, desc_ptr;
    logic [4:0]  desc_cnt;
    logic        busy, done, mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        flt_wr, mask_wr;
    logic [3:0]  flt_idx;
    logic [47:0] flt_word;
    logic [15:0] mask_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    cam_load_seq u_cam_load_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .upper_addr(upper_addr),
        .desc_ptr(desc_ptr), .desc_cnt(desc_cnt), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .flt_wr(flt_wr), .flt_idx(flt_idx),
        .flt_word(flt_word), .mask_wr(mask_wr), .mask_data(mask_data)
    );

    always #10 clk = ~clk;

    // Memory contents as a function of the byte address.
    function automatic logic [15:0] mem_word(input logic [31:0] a);
        logic [15:0] m;
        m = a[15:0] * 16'd40503;
        return m ^ a[31:16] ^ 16'h1F2E;
    endfunction

    function automatic logic [31:0] word_addr(input logic [15:0] up,
                                              input logic [15:0] base, input int n);
        logic [15:0] lo;
        lo = base + 16'(2 * n);
        return {up, lo};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_sel = 2'd3;
    endtask

    // One complete load with per-cycle checking; inject exercises R8.
    task automatic run_load(input logic [15:0] up, input logic [15:0] raw_ptr,
                            input int n, input bit inject);
        logic [15:0] base;
        int total, serv, dly, j, k;
        bit consumed, exp_f, exp_m;
        logic [31:0] da;
        logic [47:0] ew;
        base = {raw_ptr[15:1], 1'b0};
        total = 4 * n + 1;
        cfg_write(2'd0, up);
        cfg_write(2'd1, raw_ptr);
        cfg_write(2'd2, 16'hFFE0 | 16'(n));
        check(upper_addr == up, "R2", "upper readback", 64'(upper_addr), 64'(up));
        check(desc_ptr == base, "R2", "pointer bit0 forced", 64'(desc_ptr), 64'(base));
        check(desc_cnt == 5'(n), "R2", "count low bits", 64'(desc_cnt), 64'(n));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        serv = 0;
        dly = $urandom % 4;
        forever begin
            consumed = mem_ack;
            j = serv;
            exp_f = consumed && (j < 4 * n) && (j % 4 == 3);
            exp_m = consumed && (j == 4 * n);
            check(flt_wr == exp_f, "R5", "flt_wr timing", 64'(flt_wr), 64'(exp_f));
            check(mask_wr == exp_m, "R6", "mask_wr timing", 64'(mask_wr), 64'(exp_m));
            check(done == exp_m, "R6", "done timing", 64'(done), 64'(exp_m));
            if (exp_f) begin
                k = j / 4;
                da = word_addr(up, base, 4 * k);
                ew = {mem_word(word_addr(up, base, 4 * k + 3)),
                      mem_word(word_addr(up, base, 4 * k + 2)),
                      mem_word(word_addr(up, base, 4 * k + 1))};
                check(flt_idx == mem_word(da)[3:0], "R5", "slot select",
                      64'(flt_idx), 64'(mem_word(da)[3:0]));
                check(flt_word == ew, "R5", "address value", 64'(flt_word), 64'(ew));
                check(desc_cnt == 5'(n - k - 1), "R4", "count after descriptor",
                      64'(desc_cnt), 64'(n - k - 1));
            end
            if (exp_m) begin
                da = word_addr(up, base, 4 * n);
                check(mask_data == mem_word(da), "R6", "mask value",
                      64'(mask_data), 64'(mem_word(da)));
            end
            if (consumed) begin
                serv++;
                mem_ack = 1'b0;
                check(desc_ptr == word_addr(up, base, serv)[15:0], "R3", "pointer step",
                      64'(desc_ptr), 64'(word_addr(up, base, serv)[15:0]));
            end
            if (serv == total) begin
                check(busy == 1'b0, "R6", "busy clear at done", 64'(busy), 64'h0);
                break;
            end
            check(mem_req == 1'b1, "R7", "request held", 64'(mem_req), 64'h1);
            check(mem_addr == word_addr(up, base, serv), "R2", "read address",
                  64'(mem_addr), 64'(word_addr(up, base, serv)));
            if (inject) begin
                start     = (serv == 2);
                cfg_wr_en = (serv == 2);
                cfg_sel   = (serv == 2) ? 2'd2 : 2'd3;
                cfg_wdata = 16'h0007;
            end
            if (dly == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_word(mem_addr);
                dly = $urandom % 4;
            end else begin
                dly--;
            end
            @(negedge clk);
        end
        cfg_wr_en = 1'b0; start = 1'b0;
        check(desc_cnt == 5'd0, "R4", "count zero at end", 64'(desc_cnt), 64'h0);
        check(desc_ptr == word_addr(up, base, total)[15:0], "R3", "pointer past table",
              64'(desc_ptr), 64'(word_addr(up, base, total)[15:0]));
        @(negedge clk);
        check(busy == 1'b0 && mem_req == 1'b0, "R8", "idle after load",
              64'({busy, mem_req}), 64'h0);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C4_3A11));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && mem_req == 0 && flt_wr == 0 && mask_wr == 0,
              "R1", "strobes in reset", 64'({busy, done, mem_req, flt_wr, mask_wr}), 64'h0);
        check(upper_addr == 0 && desc_ptr == 0 && desc_cnt == 0, "R1", "registers in reset",
              64'({upper_addr, desc_ptr, desc_cnt}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        run_load(16'h8000, 16'h0101, 1, 1'b0);   // single descriptor, odd pointer
        run_load(16'h1234, 16'hFFF0, 16, 1'b0);  // full table, pointer wraps
        run_load(16'hABCD, 16'h0200, 0, 1'b0);   // R9: mask only
        run_load(16'h0042, 16'h0400, 3, 1'b1);   // R8: start and write while busy
        for (int r = 0; r < 12; r++)
            run_load(16'($urandom), 16'($urandom), 1 + ($urandom % 16), 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule